// File: doc/BRIEF.md
# Flash Bad-Block Map Scanner

This block runs once after reset. It walks every erase block of an attached NAND flash in ascending order and records which blocks hold a factory bad mark. For each block it fetches one marker byte from the first row. If that byte is the erased value, it also fetches the marker byte from the second row. Any marker byte other than the erased value marks the block bad. Each fetch goes through a simple byte-read request port. The block holds the request and its address steady until the flash side returns the byte with a valid strobe. Fetches may take any number of cycles.

The result is a one-bit-per-block map held in flops. A combinational lookup port answers whether a given block is usable. Software can retire further blocks through a mark-bad strobe, for example after a failed program or erase status check. The map is monotonic: bits are only ever set, and only reset clears them. The first block is guaranteed good by the flash, so it never enters the map. A running count of bad blocks and a done flag report the state of the scan.

Top module: `badblock_table`

## Requirements
- R1: After reset the map is all good, `badCount` is 0, `scanDone` is low, and in the first cycle `rdReq` is high with `rdAddr` = 0.
- R2: `rdAddr` places the block number in bits 18..12, the row within the block in bits 11..7, and the marker column (0) in bits 6..0.
- R3: A read is accepted only in a cycle where `rdReq` and `rdValid` are both high. Until then `rdReq` stays high and `rdAddr` stays unchanged, and `rdData` is ignored.
- R4: If the row-0 marker is not FFh, the block is recorded bad. Its row-1 marker is not fetched, and the scan moves on to row 0 of the next block.
- R5: If the row-0 marker is FFh, the row-1 marker is fetched. The block is bad if that byte is not FFh and good if both bytes are FFh.
- R6: Blocks are scanned in order 0 to 127. In the cycle after the last fetch of block 127 is accepted, `scanDone` goes high and `rdReq` goes low, and both stay that way until reset.
- R7: Block 0 is always reported good, whatever its markers hold and whatever is marked through the mark-bad port.
- R8: `lookupGood` is 1 when block `lookupBlk` is not in the map and 0 when it is, with no clock delay.
- R9: A `markBadValid` pulse puts block `markBadBlk` in the map from the next cycle on, both during and after the scan. Marking a block that is already bad changes nothing.
- R10: `badCount` always equals the number of blocks in the map and updates in the same cycle as the map. A block that the scan and the mark-bad port hit in the same cycle counts once. Two different blocks hit in the same cycle count twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; restarts the scan |
| rdReq | output | 1 | Byte read request to the flash side |
| rdAddr | output | 19 | Byte address of the requested marker |
| rdValid | input | 1 | Read data valid; completes the pending request |
| rdData | input | 8 | Marker byte returned by the flash side |
| markBadValid | input | 1 | Strobe: retire block `markBadBlk` |
| markBadBlk | input | 7 | Block to retire |
| lookupBlk | input | 7 | Block to query |
| lookupGood | output | 1 | 1 = queried block is usable |
| scanDone | output | 1 | Start-up scan has finished |
| badCount | output | 8 | Number of blocks in the map |

## Verification
The scan is tried with two marker layouts:
- The first layout mixes several kinds of block. Some have 00h on row 0, some have other non-erased bytes on row 0, and some are erased on row 0 but not on row 1. Block 0 carries a bad mark. This separates the skip-row-1 rule from the two-row rule and shows the block-0 exemption.
- The second layout marks the final blocks bad and puts odd values on row 1. It checks the end of the scan and the clearing of the map by a second reset.

Read latency varies from zero to two cycles with the address, which exposes any fetch taken without a valid strobe. Mark-bad pulses are timed to land in the same cycle as a scan verdict, once on the same block and once on a different block. This separates a shared counter update from two independent ones.

// File: rtl/ibt_pkg.sv
package ibt_pkg;
  // Strobes from the scan sequencer to the map datapath, all single-cycle.
  typedef struct packed {
    logic setBad;     // accepted marker byte is not erased: retire current block
    logic nextPage;   // advance to the next marker row of the current block
    logic nextBlock;  // advance to row 0 of the next block
  } scan_strobe_t;
endpackage

// File: rtl/ibt_ctrl.sv
module ibt_ctrl
  import ibt_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         rdValid,
  input  logic         markerErased,
  input  logic         onLastMarkPage,
  input  logic         onLastBlock,
  output logic         rdReq,
  output logic         scanDone,
  output scan_strobe_t ctl
);
  typedef enum logic [0:0] {ST_SCAN, ST_DONE} scan_state_t;

  scan_state_t state;
  logic        accept;
  logic        blockDecided;

  assign accept       = (state == ST_SCAN) && rdValid;
  assign blockDecided = !markerErased || onLastMarkPage;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SCAN;
    end else if (accept && blockDecided && onLastBlock) begin
      state <= ST_DONE;
    end
  end

  always_comb begin
    rdReq         = (state == ST_SCAN);
    scanDone      = (state == ST_DONE);
    ctl.setBad    = accept && !markerErased;
    ctl.nextPage  = accept && !blockDecided;
    ctl.nextBlock = accept && blockDecided && !onLastBlock;
  end

  // R3: an unanswered request is not withdrawn
  a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
    rdReq && !rdValid |=> rdReq);

  // R6: completion is permanent until reset
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    scanDone |=> scanDone && !rdReq);
endmodule

// File: rtl/ibt_datapath.sv
module ibt_datapath
  import ibt_pkg::*;
#(
  parameter int          NUM_BLOCKS      = 128,
  parameter int          PAGES_PER_BLOCK = 32,
  parameter int          PAGE_BYTES      = 128,
  parameter int          DATA_W          = 8,
  parameter int          MARK_PAGES      = 2,
  parameter int          MARKER_COL      = 0,
  parameter logic [7:0]  ERASED_VAL      = 8'hFF,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int PG_W   = $clog2(PAGES_PER_BLOCK),
  localparam int COL_W  = $clog2(PAGE_BYTES),
  localparam int ADDR_W = BLK_W + PG_W + COL_W,
  localparam int CNT_W  = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  scan_strobe_t      ctl,
  input  logic [DATA_W-1:0] rdData,
  input  logic              markBadValid,
  input  logic [BLK_W-1:0]  markBadBlk,
  input  logic [BLK_W-1:0]  lookupBlk,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              markerErased,
  output logic              onLastMarkPage,
  output logic              onLastBlock,
  output logic              lookupGood,
  output logic [CNT_W-1:0]  badCount
);
  logic [BLK_W-1:0]      blkCnt;
  logic [PG_W-1:0]       pageCnt;
  logic [NUM_BLOCKS-1:0] badMap;
  logic [NUM_BLOCKS-1:0] setVec;
  logic                  scanHit;
  logic                  markHit;

  assign markerErased   = (rdData == DATA_W'(ERASED_VAL));
  assign onLastMarkPage = (pageCnt == PG_W'(MARK_PAGES - 1));
  assign onLastBlock    = (blkCnt == BLK_W'(NUM_BLOCKS - 1));
  assign rdAddr         = {blkCnt, pageCnt, COL_W'(MARKER_COL)};
  assign lookupGood     = !badMap[lookupBlk];

  // Row/block walker
  always_ff @(posedge clk) begin
    if (rst) begin
      blkCnt  <= '0;
      pageCnt <= '0;
    end else if (ctl.nextBlock) begin
      blkCnt  <= blkCnt + 1'b1;
      pageCnt <= '0;
    end else if (ctl.nextPage) begin
      pageCnt <= pageCnt + 1'b1;
    end
  end

  // Per-block set requests; block 0 is exempt from both sources
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_set
    if (i == 0) begin : g_guaranteed
      assign setVec[i] = 1'b0;
    end else begin : g_retirable
      assign setVec[i] = (ctl.setBad && blkCnt == BLK_W'(i)) ||
                         (markBadValid && markBadBlk == BLK_W'(i));
    end
  end

  assign scanHit = ctl.setBad && (blkCnt != '0) && !badMap[blkCnt];
  assign markHit = markBadValid && (markBadBlk != '0) && !badMap[markBadBlk] &&
                   !(scanHit && markBadBlk == blkCnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      badMap   <= '0;
      badCount <= '0;
    end else begin
      badMap   <= badMap | setVec;
      badCount <= badCount + CNT_W'(scanHit) + CNT_W'(markHit);
    end
  end

  // R4: a bad verdict on a non-final block restarts at row 0
  a_r4_skip_second: assert property (@(posedge clk) disable iff (rst)
    ctl.setBad && !onLastBlock |=> pageCnt == '0);

  // R7: the first block always reads as usable
  a_r7_blk0_good: assert property (@(posedge clk) disable iff (rst)
    lookupBlk == '0 |-> lookupGood);

  // R9: a retired block shows up in the map one cycle later
  a_r9_mark_lands: assert property (@(posedge clk) disable iff (rst)
    markBadValid && markBadBlk != '0 |=> badMap[$past(markBadBlk)]);

  // R10: the count never decreases and never exceeds the retirable blocks
  a_r10_count_monotonic: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> badCount >= $past(badCount) && badCount <= CNT_W'(NUM_BLOCKS - 1));
endmodule

// File: rtl/badblock_table.sv
module badblock_table
  import ibt_pkg::*;
#(
  parameter int         NUM_BLOCKS      = 128,
  parameter int         PAGES_PER_BLOCK = 32,
  parameter int         PAGE_BYTES      = 128,
  parameter int         DATA_W          = 8,
  parameter int         MARK_PAGES      = 2,
  parameter int         MARKER_COL      = 0,
  parameter logic [7:0] ERASED_VAL      = 8'hFF
) (
  input  logic clk,
  input  logic rst,
  output logic rdReq,
  output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK)+$clog2(PAGE_BYTES)-1:0] rdAddr,
  input  logic rdValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic markBadValid,
  input  logic [$clog2(NUM_BLOCKS)-1:0] markBadBlk,
  input  logic [$clog2(NUM_BLOCKS)-1:0] lookupBlk,
  output logic lookupGood,
  output logic scanDone,
  output logic [$clog2(NUM_BLOCKS+1)-1:0] badCount
);
  scan_strobe_t ctl;
  logic         markerErased;
  logic         onLastMarkPage;
  logic         onLastBlock;

  ibt_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .rdValid        (rdValid),
    .markerErased   (markerErased),
    .onLastMarkPage (onLastMarkPage),
    .onLastBlock    (onLastBlock),
    .rdReq          (rdReq),
    .scanDone       (scanDone),
    .ctl            (ctl)
  );

  ibt_datapath #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .PAGE_BYTES      (PAGE_BYTES),
    .DATA_W          (DATA_W),
    .MARK_PAGES      (MARK_PAGES),
    .MARKER_COL      (MARKER_COL),
    .ERASED_VAL      (ERASED_VAL)
  ) u_dp (
    .clk            (clk),
    .rst            (rst),
    .ctl            (ctl),
    .rdData         (rdData),
    .markBadValid   (markBadValid),
    .markBadBlk     (markBadBlk),
    .lookupBlk      (lookupBlk),
    .rdAddr         (rdAddr),
    .markerErased   (markerErased),
    .onLastMarkPage (onLastMarkPage),
    .onLastBlock    (onLastBlock),
    .lookupGood     (lookupGood),
    .badCount       (badCount)
  );

  // R3: the address of a pending fetch does not move
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
    rdReq && !rdValid |=> $stable(rdAddr));
endmodule

// File: tb/badblock_table_test.sv
`timescale 1ns/1ps
module badblock_table_test;
  localparam int NB = 128;
  localparam logic [7:0] ERASED = 8'hFF;

  logic        clk = 1'b0;
  logic        rst;
  logic        rdReq;
  logic [18:0] rdAddr;
  logic        rdValid;
  logic [7:0]  rdData;
  logic        markBadValid;
  logic [6:0]  markBadBlk;
  logic [6:0]  lookupBlk;
  logic        lookupGood;
  logic        scanDone;
  logic [7:0]  badCount;

  int nChecks = 0;
  int nFail   = 0;
  int pat     = 0;
  int waitCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  badblock_table uut (
    .clk(clk), .rst(rst), .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .markBadValid(markBadValid), .markBadBlk(markBadBlk),
    .lookupBlk(lookupBlk), .lookupGood(lookupGood), .scanDone(scanDone),
    .badCount(badCount)
  );

  // Marker contents of the emulated flash for the two layouts
  function automatic logic [7:0] markerByte(int b, int p);
    if (pat == 0) begin
      if (b == 0 && p == 0)       return 8'h00;
      if (b % 7 == 3 && p == 0)   return 8'h00;
      if (b % 11 == 5 && p == 1)  return 8'h00;
      if (b % 13 == 6 && p == 0)  return 8'h5A;
      if (b % 17 == 9 && p == 1)  return 8'hFE;
      return ERASED;
    end
    if (b >= 124 && p == 0)  return 8'h00;
    if (b % 5 == 2 && p == 1) return 8'h7F;
    if (b == 0 && p == 1)    return 8'h00;
    return ERASED;
  endfunction

  function automatic int latencyOf(int b, int p);
    return (b + p + pat) % 3;
  endfunction

  function automatic bit expScanBad(int b);
    return (b != 0) && (markerByte(b, 0) != ERASED || markerByte(b, 1) != ERASED);
  endfunction

  assign rdValid = rdReq && (waitCnt >= latencyOf(int'(rdAddr[18:12]), int'(rdAddr[11:7])));
  assign rdData  = rdValid ? markerByte(int'(rdAddr[18:12]), int'(rdAddr[11:7])) : 8'h00;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit mBad [NB];
  bit readSeen [NB][32];
  int mBlk, mPage, mCount, scanSet;
  bit mDone;
  bit modelOn = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      mBlk = 0; mPage = 0; mDone = 0; mCount = 0;
      for (int i = 0; i < NB; i++) begin
        mBad[i] = 0;
        for (int j = 0; j < 32; j++) readSeen[i][j] = 0;
      end
      waitCnt <= 0;
    end else begin
      scanSet = -1;
      if (rdReq && rdValid) readSeen[rdAddr[18:12]][rdAddr[11:7]] = 1;
      if (!mDone && rdValid) begin
        if (rdData != ERASED) scanSet = mBlk;
        if (rdData != ERASED || mPage == 1) begin
          if (mBlk == NB - 1) mDone = 1;
          else begin mBlk++; mPage = 0; end
        end else begin
          mPage++;
        end
      end
      if (scanSet > 0 && !mBad[scanSet]) begin mBad[scanSet] = 1; mCount++; end
      if (markBadValid && markBadBlk != 0 && !mBad[markBadBlk]) begin
        mBad[markBadBlk] = 1; mCount++;
      end
      waitCnt <= (!rdReq || rdValid) ? 0 : waitCnt + 1;
    end
  end

  bit holdPrev = 0;
  logic [18:0] prevAddr;
  always @(negedge clk) begin
    if (!rst && modelOn) begin
      check(rdReq == !mDone, "R6 request level", rdReq, !mDone);
      if (!mDone)
        check(rdAddr == 19'((mBlk << 12) | (mPage << 7)), "R2 fetch address",
              rdAddr, (mBlk << 12) | (mPage << 7));
      check(scanDone == mDone, "R6 done flag", scanDone, mDone);
      check(badCount == 8'(mCount), "R10 count", badCount, mCount);
      check(lookupGood == !mBad[lookupBlk], "R8 lookup", lookupGood, !mBad[lookupBlk]);
      if (holdPrev) check(rdAddr == prevAddr && rdReq, "R3 held request", rdAddr, prevAddr);
      holdPrev = rdReq && !rdValid;
      prevAddr = rdAddr;
    end else begin
      holdPrev = 0;
    end
  end

  task automatic runScan(input bit withMarks);
    int guard;
    bit d3, d10, d50;
    guard = 0; d3 = 0; d10 = 0; d50 = 0;
    while (!scanDone && guard < 5000) begin
      @(posedge clk); #1;
      markBadValid = 0;
      lookupBlk = lookupBlk + 7'd37;
      if (withMarks && rdReq && rdValid) begin
        if (!d3 && rdAddr[18:12] == 7'd3) begin          // R10 same block, same cycle
          markBadValid = 1; markBadBlk = 7'd3; d3 = 1;
        end else if (!d10 && rdAddr[18:12] == 7'd10) begin // R10 other block, same cycle
          markBadValid = 1; markBadBlk = 7'd40; d10 = 1;
        end else if (!d50 && rdAddr[18:12] == 7'd50) begin // R9 mark during scan
          markBadValid = 1; markBadBlk = 7'd1; d50 = 1;
        end
      end
      guard++;
    end
    @(posedge clk); #1 markBadValid = 0;
  endtask

  task automatic lookupAt(input int b, output bit good);
    @(posedge clk); #1 lookupBlk = 7'(b);
    @(negedge clk); good = lookupGood;
  endtask

  int expCount;
  bit g;
  initial begin
    rst = 1; markBadValid = 0; markBadBlk = 0; lookupBlk = 0; pat = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(rdReq == 1 && rdAddr == 0, "R1 first fetch", rdAddr, 0);
    check(scanDone == 0, "R1 done low", scanDone, 0);
    check(badCount == 0, "R1 count zero", badCount, 0);
    check(lookupGood == 1, "R1 map clear", lookupGood, 1);
    modelOn = 1;
    runScan(1);

    expCount = 0;
    for (int i = 0; i < NB; i++) begin
      bit eb;
      eb = expScanBad(i) || i == 3 || i == 40 || i == 1;
      if (eb) expCount++;
      lookupAt(i, g);
      check(g == !eb, $sformatf("R8 block %0d verdict", i), g, !eb);
    end
    check(badCount == 8'(expCount), "R10 total after scan", badCount, expCount);
    check(!readSeen[3][1] && readSeen[3][0], "R4 row 1 skipped", readSeen[3][1], 0);
    lookupAt(6, g);  check(g == 0, "R4 non-00 marker bad", g, 0);
    check(readSeen[5][1], "R5 row 1 fetched", readSeen[5][1], 1);
    lookupAt(5, g);  check(g == 0, "R5 row 1 bad", g, 0);
    lookupAt(9, g);  check(g == 0, "R5 row 1 FE bad", g, 0);
    lookupAt(2, g);  check(g == 1 && readSeen[2][1], "R5 both erased good", g, 1);
    lookupAt(0, g);  check(g == 1, "R7 block 0 marker ignored", g, 1);
    repeat (4) begin
      @(negedge clk);
      check(!rdReq && scanDone, "R6 quiet after scan", rdReq, 0);
    end

    @(posedge clk); #1 markBadValid = 1; markBadBlk = 7'd62; lookupBlk = 7'd62;
    @(negedge clk); check(lookupGood == 1, "R9 not yet retired", lookupGood, 1);
    @(posedge clk); #1 markBadValid = 0;
    @(negedge clk); check(lookupGood == 0, "R9 retired next cycle", lookupGood, 0);
    check(badCount == 8'(expCount + 1), "R10 count after mark", badCount, expCount + 1);
    @(posedge clk); #1 markBadValid = 1; markBadBlk = 7'd3;
    @(posedge clk); #1 markBadValid = 1; markBadBlk = 7'd0; lookupBlk = 7'd0;
    @(posedge clk); #1 markBadValid = 0;
    @(negedge clk);
    check(badCount == 8'(expCount + 1), "R9 repeat mark no change", badCount, expCount + 1);
    check(lookupGood == 1, "R7 block 0 mark ignored", lookupGood, 1);

    modelOn = 0;
    pat = 1;
    @(posedge clk); #1 rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0; lookupBlk = 7'd62;
    @(negedge clk);
    check(badCount == 0 && !scanDone, "R1 reset clears count", badCount, 0);
    check(lookupGood == 1, "R1 reset clears map", lookupGood, 1);
    modelOn = 1;
    runScan(0);
    expCount = 0;
    for (int i = 0; i < NB; i++) if (expScanBad(i)) expCount++;
    check(badCount == 8'(expCount), "R10 total second layout", badCount, expCount);
    lookupAt(127, g); check(g == 0, "R6 last block scanned", g, 0);
    check(scanDone == 1, "R6 done after last block", scanDone, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R6 watchdog actual=%0h expected=%0h", scanDone, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule